// File: doc/BRIEF.md
# Circular Capture Sequencer with Arming and Post-Trigger Stop

This block sequences a logic analyzer's sample buffer as a ring. On every sample clock it steps a 13-bit write address for an external 8192-word sample memory. A sticky flag records that the address has passed from its top value back to zero. Matches from the trigger comparator are ignored until the address has reached an arming level. The default level of 4096 ensures that the pre-trigger half of the ring holds real samples before a trigger can land. A match can be accepted on a single sample edge or only after two consecutive matching edges.

Once a trigger is accepted, a fixed window of 4096 further sample clocks runs. At its end the run flag drops, and this freezes both the address and the window counter. The ring then holds 4K samples before the trigger point and 4K after it. The host polls the run flag. To read the buffer back, it deasserts write enable, which disables triggering. It then issues a master reset and clocks the block from a software-driven clock, which steps the same address from 0. The sample clock multiplexer and the memory array lie outside this block.

Top module: `capture_sequencer`

## Requirements
- R1: With rst_n low at a rising clk edge, the edge clears addr_o to 0, wrap_o to 0 and trig_o to 0, and sets run_o to 1.
- R2: While run_o is 1, each rising edge raises addr_o by exactly one. The count is modulo 8192, so 0x1FFF is followed by 0.
- R3: wrap_o goes to 1 on the edge where addr_o passes from 0x1FFF to 0. It stays 1 through later counting and after a stop, and only a reset clears it.
- R4: A match is accepted only at an edge where addr_o is at least ARM_MIN (4096), or after that level has once been reached since reset. A match seen at an edge with addr_o at 4095 or below leaves trig_o at 0.
- R5: With qual2_i low, an armed edge with match_i and wen_i both high sets trig_o after that edge.
- R6: With qual2_i high, trig_o sets only after two consecutive armed edges that both have match_i high. An isolated one-edge match is ignored.
- R7: trig_o is sticky. After it is set, further matches have no effect on trig_o, on addr_o or on the timing of the stop.
- R8: Let T be the addr_o value in the first cycle with trig_o high. run_o falls exactly 4096 edges later, with addr_o at (T + 4096) mod 8192. After that, addr_o and run_o stay unchanged until reset.
- R9: While wen_i is 0, no match is accepted and run_o stays 1. After a reset, addr_o steps 0, 1, 2 and so on, one value per rising edge, for readout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Selected sample clock (software clock during readout) |
| rst_n | input | 1 | Master reset, active low, sampled on the rising edge |
| match_i | input | 1 | Trigger comparator result for the current sample |
| qual2_i | input | 1 | 1: require two consecutive matching edges |
| wen_i | input | 1 | Acquisition write enable; 0 disables triggering |
| addr_o | output | 13 | Sample memory write/read address |
| wrap_o | output | 1 | Sticky address rollover flag |
| trig_o | output | 1 | Sticky trigger accepted flag |
| run_o | output | 1 | High while acquisition continues; low when the post-trigger window is over |

## Verification
The following properties are checked on every cycle:
- The address increments by one while running and holds when stopped.
- The wrap flag is set at rollover and is sticky.
- The trigger and stop flags are sticky.
- A trigger never rises without arming.
- Two-edge qualification is honoured.
- Run never falls before 4096 counted post-trigger edges.

Other behaviour shows up only in the bench scenarios: the exact 4095/4096 arming boundary, the final address modulo the ring size, and whether late matches disturb the stop. The bench also covers triggering being suppressed while write enable is low, and the readout stepping after a reset.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;
    localparam int DEF_ADDR_W  = 13;
    localparam int DEF_ARM_MIN = 4096;
    localparam int DEF_POST    = 4096;

    typedef struct packed {
        logic prev;   // qualified match seen on the previous edge
        logic trig;   // sticky trigger flag
    } qual_state_t;
endpackage

// File: rtl/cap_addr_ctr.sv
module cap_addr_ctr #(
    parameter int ADDR_W  = cap_seq_pkg::DEF_ADDR_W,
    parameter int ARM_MIN = cap_seq_pkg::DEF_ARM_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o,
    output logic              armed_o
);
    localparam logic [ADDR_W-1:0] ARM_V = ADDR_W'(ARM_MIN);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wrap;
        logic              armed;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       armed_now;

    always_comb begin
        armed_now = st_q.armed | (st_q.addr >= ARM_V);
        st_d      = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else begin
            st_d.armed = armed_now;
            if (run_i) begin
                st_d.addr = st_q.addr + 1'b1;
                if (&st_q.addr) begin
                    st_d.wrap = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr_o  = st_q.addr;
    assign wrap_o  = st_q.wrap;
    assign armed_o = armed_now;
endmodule

// File: rtl/cap_trig_qual.sv
module cap_trig_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic wen_i,
    input  logic armed_i,
    input  logic match_i,
    input  logic qual2_i,
    output logic trig_o
);
    import cap_seq_pkg::*;

    qual_state_t st_d, st_q;
    logic        valid_now;
    logic        hit;

    always_comb begin
        valid_now = armed_i & wen_i & match_i;
        hit       = valid_now & (qual2_i ? st_q.prev : 1'b1);
        st_d      = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else begin
            st_d.prev = valid_now;
            st_d.trig = st_q.trig | (hit & run_i);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign trig_o = st_q.trig;
endmodule

// File: rtl/cap_post_ctr.sv
module cap_post_ctr #(
    parameter int POST_LEN = cap_seq_pkg::DEF_POST
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic run_o
);
    localparam int             CNT_W = $clog2(POST_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POST_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } post_state_t;

    post_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.cnt = '0;
            st_d.run = 1'b1;
        end else if (trig_i && st_q.run) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign run_o = st_q.run;
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
    parameter int ADDR_W   = cap_seq_pkg::DEF_ADDR_W,
    parameter int ARM_MIN  = cap_seq_pkg::DEF_ARM_MIN,
    parameter int POST_LEN = cap_seq_pkg::DEF_POST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_i,
    input  logic              qual2_i,
    input  logic              wen_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o,
    output logic              trig_o,
    output logic              run_o
);
    logic armed;

    cap_addr_ctr #(.ADDR_W(ADDR_W), .ARM_MIN(ARM_MIN)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_o),
        .addr_o  (addr_o),
        .wrap_o  (wrap_o),
        .armed_o (armed)
    );

    cap_trig_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_o),
        .wen_i   (wen_i),
        .armed_i (armed),
        .match_i (match_i),
        .qual2_i (qual2_i),
        .trig_o  (trig_o)
    );

    cap_post_ctr #(.POST_LEN(POST_LEN)) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_o),
        .run_o  (run_o)
    );
endmodule

// File: rtl/cap_seq_checker.sv
module cap_seq_checker #(
    parameter int ADDR_W   = 13,
    parameter int POST_LEN = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              match,
    input logic              qual2,
    input logic [ADDR_W-1:0] addr,
    input logic              wrap,
    input logic              trig,
    input logic              run,
    input logic              armed
);
    localparam int CW = $clog2(POST_LEN + 1) + 1;
    logic [CW-1:0] post_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) post_seen <= '0;
        else if (trig && run) post_seen <= post_seen + 1'b1;
    end

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> addr == $past(addr) + 1'b1);
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(addr));
    assert_wrap_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (&addr)) |=> wrap);
    assert_wrap_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> wrap);
    assert_trig_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> trig);
    assert_trig_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(armed));
    assert_two_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trig) && $past(qual2)) |-> ($past(match) && $past(match, 2)));
    assert_stop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> post_seen == CW'(POST_LEN));
    assert_no_early_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> post_seen < CW'(POST_LEN));
    assert_stop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !run);
endmodule

bind capture_sequencer cap_seq_checker #(.ADDR_W(ADDR_W), .POST_LEN(POST_LEN)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .match (match_i),
    .qual2 (qual2_i),
    .addr  (addr_o),
    .wrap  (wrap_o),
    .trig  (trig_o),
    .run   (run_o),
    .armed (armed)
);

// File: tb/capture_sequencer_bench.sv
module capture_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        match = 1'b0;
    logic        qual2 = 1'b0;
    logic        wen = 1'b1;
    logic [12:0] addr;
    logic        wrap, trig, run;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    capture_sequencer u_capture_sequencer (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .qual2_i (qual2),
        .wen_i   (wen),
        .addr_o  (addr),
        .wrap_o  (wrap),
        .trig_o  (trig),
        .run_o   (run)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
    endtask

    task automatic run_out(input int t_addr, input bit exp_wrap, input bit toggle);
        int cnt = 0;
        while (run && cnt < 5000) begin
            if (toggle) match = ~match;
            step(1);
            cnt++;
        end
        match = 1'b0;
        chk("R8 stop edges", cnt, 4096);
        chk("R8 final addr", addr, (t_addr + 4096) % 8192);
        chk("R3 wrap after stop", wrap, exp_wrap);
        match = 1'b1;
        step(3);
        match = 1'b0;
        chk("R8 addr frozen", addr, (t_addr + 4096) % 8192);
        chk("R8 run stays low", run, 0);
        chk("R7 trig held", trig, 1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 addr", addr, 0);
        chk("R1 wrap", wrap, 0);
        chk("R1 trig", trig, 0);
        chk("R1 run", run, 1);
        step(37);
        chk("R2 count", addr, 37);
    endtask

    task automatic t_single_edge();
        wen = 1'b1; qual2 = 1'b0; match = 1'b0;
        do_reset();
        step(100);
        match = 1'b1; step(1); match = 1'b0;
        chk("R4 early match ignored", trig, 0);
        step(4095 - 101);
        chk("R2 addr before arm", addr, 4095);
        match = 1'b1; step(1);
        chk("R4 match at 4095 ignored", trig, 0);
        step(1);
        match = 1'b0;
        chk("R5 single edge trigger", trig, 1);
        chk("R5 trigger addr", addr, 4097);
        run_out(4097, 1'b1, 1'b0);
    endtask

    task automatic t_two_edge();
        wen = 1'b1; qual2 = 1'b1; match = 1'b0;
        do_reset();
        step(5000);
        for (int i = 0; i < 3; i++) begin
            match = 1'b1; step(1); match = 1'b0; step(1);
        end
        chk("R6 isolated match ignored", trig, 0);
        match = 1'b1; step(1);
        chk("R6 first of two", trig, 0);
        step(1);
        chk("R6 two edges trigger", trig, 1);
        chk("R6 trigger addr", addr, 5008);
        run_out(5008, 1'b1, 1'b1);
    endtask

    task automatic t_wrap_readout();
        wen = 1'b0; qual2 = 1'b0; match = 1'b1;
        do_reset();
        step(8191);
        chk("R2 top addr", addr, 8191);
        chk("R3 wrap before roll", wrap, 0);
        chk("R9 no trig wen low", trig, 0);
        step(1);
        chk("R2 roll to zero", addr, 0);
        chk("R3 wrap set", wrap, 1);
        step(5000);
        chk("R3 wrap sticky", wrap, 1);
        chk("R9 run stays high", run, 1);
        chk("R9 still no trig", trig, 0);
        match = 1'b0;
        do_reset();
        chk("R3 wrap cleared", wrap, 0);
        for (int k = 1; k <= 4; k++) begin
            step(1);
            chk("R9 readout step", addr, k);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single_edge();
        t_two_edge();
        t_wrap_readout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule